// File: doc/BRIEF.md
# Crosspoint-Buffered Priority Crossbar Switch

This block is a square switch fabric that moves byte streams from any of its input ports to any of its output ports. Every input byte carries a destination output number and a two-bit urgency level. Storage is not at the inputs but at the crosspoints: for every (input, output, level) triple there is a private first-in first-out queue. An input therefore only ever waits on the one queue it is addressing, and traffic for a busy output never holds back traffic for an idle one.

Each output column has its own arbiter. It is a two-state machine that owns a one-byte output stage. The states are `OUT_EMPTY` and `OUT_LOADED`. `OUT_EMPTY` moves to `OUT_LOADED` when any queue in the column holds data. `OUT_LOADED` stays in `OUT_LOADED` while the downstream is stalled, or when a transfer happens and another byte is waiting. `OUT_LOADED` returns to `OUT_EMPTY` when a transfer happens and the column is empty. On every load the arbiter picks the most urgent non-empty level. Within that level it rotates among inputs with a pointer per level, and the pointer moves only when a byte is granted.

The port count, the number of levels, the queue depth and the byte width are parameters. The full-size configuration is 16 ports, 4 levels and 128-byte queues, which gives 1,024 queues. The default build is smaller so that it stays light to elaborate.

Top module: `xbar_switch`

## Requirements
- R1: A synchronous active-high reset empties every crosspoint queue and clears every arbiter pointer. In the first cycle after reset, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: A byte accepted on input i (valid and ready high at a clock edge) with destination d and level p appears only on output d, one clock edge later. It carries the same data, with `out_src` = i and `out_prio` = p.
- R3: `in_ready[i]` is low exactly when the queue addressed by input i's current destination and level holds DEPTH bytes. With output d stalled, one crosspoint absorbs DEPTH+1 bytes: DEPTH in the queue and one in the output stage.
- R4: An input refused by a full queue toward one output is accepted in the same cycle when it addresses a different output.
- R5: The level is the 2-bit value on `in_prio`, and a larger value is more urgent. At every load an output takes a byte from the most urgent level that has a non-empty queue in its column.
- R6: Within one level, an output serves inputs round-robin. After reset the search starts at input 0. After a grant to input i, the search for that level starts at input i+1, wrapping to 0.
- R7: While `out_valid[d]` is high and `out_ready[d]` is low, `out_valid[d]`, `out_data`, `out_src` and `out_prio` of output d hold their values. A byte leaves only in a cycle with both high.
- R8: Bytes from one crosspoint leave in arrival order. With the downstream ready they leave at one byte per cycle.
- R9: Data, destination, level and source fields are packed per port. Port k uses bits [8k+7:8k] of the data buses, and bits [w*k+w-1:w*k] of the destination, level and source buses, where w is that field's width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NPORTS | Input k presents a byte |
| in_data | input | NPORTS*DATA_W | Input bytes, packed per port |
| in_dest | input | NPORTS*log2(NPORTS) | Destination output per input |
| in_prio | input | NPORTS*log2(NPRIO) | Urgency level per input, larger is more urgent |
| in_ready | output | NPORTS | Addressed crosspoint queue has room |
| out_valid | output | NPORTS | Output stage holds a byte |
| out_data | output | NPORTS*DATA_W | Output bytes, packed per port |
| out_src | output | NPORTS*log2(NPORTS) | Input the byte came from |
| out_prio | output | NPORTS*log2(NPRIO) | Level of the byte |
| out_ready | input | NPORTS | Downstream accepts the byte |

## Verification
The bench builds the switch with 4 ports, 4 levels and a queue depth of 4. The shallow depth lets a single stalled crosspoint fill up within a handful of cycles, so backpressure, the exact DEPTH+1 absorption count and the unblocked neighbouring destination are all reached quickly. Four ports and four levels cover the full 2-bit destination and level encodings, and let three inputs contend for one output at one level so the pointer wrap-around shows up.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // Output stage of one column arbiter.
    typedef enum logic [0:0] {
        OUT_EMPTY  = 1'b0,
        OUT_LOADED = 1'b1
    } out_state_e;

endpackage

// File: rtl/xbar_xpt_fifo.sv
// One crosspoint queue: show-ahead head, one write and one read per cycle.
module xbar_xpt_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              not_empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic              wr_ok;
    logic              rd_ok;

    assign full      = (count == CW'(DEPTH));
    assign not_empty = (count != '0);
    assign wr_ok     = wr_en && !full;
    assign rd_ok     = rd_en && not_empty;
    assign rd_data   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_ok) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/xbar_ingress.sv
// Steers one input byte to the queue picked by destination and level.
// Queue order in the row: output o, level p at index o*NPRIO + p.
module xbar_ingress #(
    parameter int NPORTS = 4,
    parameter int NPRIO  = 4
) (
    input  logic                       valid,
    input  logic [$clog2(NPORTS)-1:0]  dest,
    input  logic [$clog2(NPRIO)-1:0]   prio,
    input  logic [NPORTS*NPRIO-1:0]    full_row,
    output logic                       ready,
    output logic [NPORTS*NPRIO-1:0]    wr_row
);
    localparam int ROW = NPORTS * NPRIO;

    int sel;

    always_comb begin
        sel    = int'(dest) * NPRIO + int'(prio);
        ready  = 1'b0;
        wr_row = '0;
        for (int k = 0; k < ROW; k++) begin
            if (k == sel) begin
                ready     = !full_row[k];
                wr_row[k] = valid && !full_row[k];
            end
        end
    end

endmodule

// File: rtl/xbar_egress_arb.sv
// Column arbiter for one output: strict level order, round-robin per level.
// Column order: level p, input i at index p*NPORTS + i.
module xbar_egress_arb
    import xbar_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int NPRIO  = 4,
    parameter int DATA_W = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NPRIO*NPORTS-1:0]          nonempty,
    input  logic [NPRIO*NPORTS*DATA_W-1:0]   head_data,
    output logic [NPRIO*NPORTS-1:0]          pop,
    output logic                             out_valid,
    output logic [DATA_W-1:0]                out_data,
    output logic [$clog2(NPORTS)-1:0]        out_src,
    output logic [$clog2(NPRIO)-1:0]         out_prio,
    input  logic                             out_ready
);
    localparam int DW = $clog2(NPORTS);
    localparam int PW = $clog2(NPRIO);

    out_state_e                  state;
    out_state_e                  state_nxt;
    logic [NPRIO-1:0][DW-1:0]    rr_ptr;
    logic [NPRIO-1:0]            lvl_hit;
    logic [NPRIO-1:0][DW-1:0]    lvl_pick;
    logic                        req_any;
    logic [PW-1:0]               win_p;
    logic [DW-1:0]               win_i;
    logic                        load;

    // Per level: first non-empty input at or after the rotating pointer.
    for (genvar gp = 0; gp < NPRIO; gp++) begin : g_level
        always_comb begin
            int idx;
            lvl_hit[gp]  = 1'b0;
            lvl_pick[gp] = '0;
            for (int k = 0; k < NPORTS; k++) begin
                idx = (int'(rr_ptr[gp]) + k) % NPORTS;
                if (!lvl_hit[gp] && nonempty[gp*NPORTS + idx]) begin
                    lvl_hit[gp]  = 1'b1;
                    lvl_pick[gp] = DW'(idx);
                end
            end
        end
    end

    // Most urgent level wins: scan upward, the last hit overrides.
    always_comb begin
        req_any = 1'b0;
        win_p   = '0;
        win_i   = '0;
        for (int p = 0; p < NPRIO; p++) begin
            if (lvl_hit[p]) begin
                req_any = 1'b1;
                win_p   = PW'(p);
                win_i   = lvl_pick[p];
            end
        end
    end

    assign load = req_any && ((state == OUT_EMPTY) || out_ready);

    always_comb begin
        pop = '0;
        if (load) begin
            pop[int'(win_p)*NPORTS + int'(win_i)] = 1'b1;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nxt = state;
        unique case (state)
            OUT_EMPTY: begin
                if (req_any) begin
                    state_nxt = OUT_LOADED;
                end
            end
            OUT_LOADED: begin
                if (out_ready && !req_any) begin
                    state_nxt = OUT_EMPTY;
                end
            end
            default: state_nxt = OUT_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= OUT_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    // Output stage and rotating pointers.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
            out_src  <= '0;
            out_prio <= '0;
            rr_ptr   <= '0;
        end else if (load) begin
            out_data <= head_data[(int'(win_p)*NPORTS + int'(win_i))*DATA_W +: DATA_W];
            out_src  <= win_i;
            out_prio <= win_p;
            rr_ptr[win_p] <= (win_i == DW'(NPORTS - 1)) ? '0 : win_i + 1'b1;
        end
    end

    assign out_valid = (state == OUT_LOADED);

endmodule

// File: rtl/xbar_switch.sv
// N x N byte switch with one queue per (input, output, level).
module xbar_switch #(
    parameter int NPORTS = 4,
    parameter int NPRIO  = 4,
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NPORTS-1:0]                   in_valid,
    input  logic [NPORTS*DATA_W-1:0]            in_data,
    input  logic [NPORTS*$clog2(NPORTS)-1:0]    in_dest,
    input  logic [NPORTS*$clog2(NPRIO)-1:0]     in_prio,
    output logic [NPORTS-1:0]                   in_ready,
    output logic [NPORTS-1:0]                   out_valid,
    output logic [NPORTS*DATA_W-1:0]            out_data,
    output logic [NPORTS*$clog2(NPORTS)-1:0]    out_src,
    output logic [NPORTS*$clog2(NPRIO)-1:0]     out_prio,
    input  logic [NPORTS-1:0]                   out_ready
);
    localparam int DW  = $clog2(NPORTS);
    localparam int PW  = $clog2(NPRIO);
    localparam int ROW = NPORTS * NPRIO;

    logic [NPORTS-1:0][ROW-1:0]        full_row;
    logic [NPORTS-1:0][ROW-1:0]        wr_row;
    logic [NPORTS-1:0][ROW-1:0]        col_ne;
    logic [NPORTS-1:0][ROW-1:0]        col_pop;
    logic [NPORTS-1:0][ROW*DATA_W-1:0] col_data;

    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_in
        xbar_ingress #(
            .NPORTS (NPORTS),
            .NPRIO  (NPRIO)
        ) i_ingress (
            .valid    (in_valid[gi]),
            .dest     (in_dest[gi*DW +: DW]),
            .prio     (in_prio[gi*PW +: PW]),
            .full_row (full_row[gi]),
            .ready    (in_ready[gi]),
            .wr_row   (wr_row[gi])
        );

        for (genvar go = 0; go < NPORTS; go++) begin : g_out
            for (genvar gp = 0; gp < NPRIO; gp++) begin : g_lvl
                xbar_xpt_fifo #(
                    .DEPTH  (DEPTH),
                    .DATA_W (DATA_W)
                ) i_queue (
                    .clk       (clk),
                    .rst       (rst),
                    .wr_en     (wr_row[gi][go*NPRIO + gp]),
                    .wr_data   (in_data[gi*DATA_W +: DATA_W]),
                    .rd_en     (col_pop[go][gp*NPORTS + gi]),
                    .rd_data   (col_data[go][(gp*NPORTS + gi)*DATA_W +: DATA_W]),
                    .full      (full_row[gi][go*NPRIO + gp]),
                    .not_empty (col_ne[go][gp*NPORTS + gi])
                );
            end
        end
    end

    for (genvar go = 0; go < NPORTS; go++) begin : g_arb
        xbar_egress_arb #(
            .NPORTS (NPORTS),
            .NPRIO  (NPRIO),
            .DATA_W (DATA_W)
        ) i_arb (
            .clk       (clk),
            .rst       (rst),
            .nonempty  (col_ne[go]),
            .head_data (col_data[go]),
            .pop       (col_pop[go]),
            .out_valid (out_valid[go]),
            .out_data  (out_data[go*DATA_W +: DATA_W]),
            .out_src   (out_src[go*DW +: DW]),
            .out_prio  (out_prio[go*PW +: PW]),
            .out_ready (out_ready[go])
        );
    end

endmodule

// File: rtl/xbar_switch_chk.sv
module xbar_switch_chk #(
    parameter int NPORTS = 4,
    parameter int NPRIO  = 4,
    parameter int DATA_W = 8
) (
    input logic                             clk,
    input logic                             rst,
    input logic [NPORTS-1:0]                in_ready,
    input logic [NPORTS-1:0]                out_valid,
    input logic [NPORTS*DATA_W-1:0]         out_data,
    input logic [NPORTS*$clog2(NPORTS)-1:0] out_src,
    input logic [NPORTS*$clog2(NPRIO)-1:0]  out_prio,
    input logic [NPORTS-1:0]                out_ready
);
    localparam int DW = $clog2(NPORTS);
    localparam int PW = $clog2(NPRIO);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_valid == '0));

    p_reset_ready_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&in_ready));

    for (genvar go = 0; go < NPORTS; go++) begin : g_port
        p_hold_valid_r7: assert property (@(posedge clk) disable iff (rst)
            (out_valid[go] && !out_ready[go]) |=> out_valid[go]);

        p_hold_fields_r7: assert property (@(posedge clk) disable iff (rst)
            (out_valid[go] && !out_ready[go]) |=>
                ($stable(out_data[go*DATA_W +: DATA_W]) &&
                 $stable(out_src[go*DW +: DW]) &&
                 $stable(out_prio[go*PW +: PW])));
    end

endmodule

bind xbar_switch xbar_switch_chk #(
    .NPORTS (NPORTS),
    .NPRIO  (NPRIO),
    .DATA_W (DATA_W)
) i_xbar_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_src   (out_src),
    .out_prio  (out_prio),
    .out_ready (out_ready)
);

// File: tb/test_xbar_switch.sv
module test_xbar_switch;
    localparam int N  = 4;
    localparam int P  = 4;
    localparam int D  = 4;
    localparam int W  = 8;
    localparam int DW = 2;
    localparam int PW = 2;

    // {src, dest, level, byte}
    localparam logic [13:0] VEC [8] = '{
        {2'd0, 2'd0, 2'd0, 8'hA5},
        {2'd1, 2'd2, 2'd3, 8'h3C},
        {2'd2, 2'd1, 2'd1, 8'h81},
        {2'd3, 2'd3, 2'd2, 8'hFF},
        {2'd0, 2'd3, 2'd1, 8'h00},
        {2'd3, 2'd0, 2'd0, 8'h7E},
        {2'd1, 2'd1, 2'd2, 8'h12},
        {2'd2, 2'd2, 2'd3, 8'hC9}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [N-1:0]     in_valid;
    logic [N*W-1:0]   in_data;
    logic [N*DW-1:0]  in_dest;
    logic [N*PW-1:0]  in_prio;
    logic [N-1:0]     in_ready;
    logic [N-1:0]     out_valid;
    logic [N*W-1:0]   out_data;
    logic [N*DW-1:0]  out_src;
    logic [N*PW-1:0]  out_prio;
    logic [N-1:0]     out_ready;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xbar_switch #(.NPORTS(N), .NPRIO(P), .DEPTH(D), .DATA_W(W)) i_xbar_switch (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_dest(in_dest),
        .in_prio(in_prio), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_src(out_src),
        .out_prio(out_prio), .out_ready(out_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_in(input int i, input int d, input int p, input int b);
        in_valid[i]        = 1'b1;
        in_dest[i*DW +: DW] = DW'(d);
        in_prio[i*PW +: PW] = PW'(p);
        in_data[i*W +: W]   = W'(b);
    endtask

    task automatic do_reset();
        rst       = 1'b1;
        in_valid  = '0;
        in_data   = '0;
        in_dest   = '0;
        in_prio   = '0;
        out_ready = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge.
    task automatic push(input int i, input int d, input int p, input int b, output bit acc);
        set_in(i, d, p, b);
        #1 acc = in_ready[i];
        @(negedge clk);
        in_valid[i] = 1'b0;
    endtask

    task automatic expect_out(input int o, input int s, input int p, input int b, input string req);
        chk({req, " valid"}, int'(out_valid[o]), 1);
        chk({req, " data"},  int'(out_data[o*W +: W]), b);
        chk({req, " src"},   int'(out_src[o*DW +: DW]), s);
        chk({req, " level"}, int'(out_prio[o*PW +: PW]), p);
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit acc;

        // R1: state right after reset
        do_reset();
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 in_ready after reset", int'(in_ready), 4'hF);

        // R2 / R9: routing table, downstream always ready
        for (int v = 0; v < 8; v++) begin
            int s = int'(VEC[v][13:12]);
            int d = int'(VEC[v][11:10]);
            int p = int'(VEC[v][9:8]);
            int b = int'(VEC[v][7:0]);
            push(s, d, p, b, acc);
            chk("R2 accepted", int'(acc), 1);
            @(negedge clk);
            chk("R2 only destination valid", int'(out_valid), 1 << d);
            expect_out(d, s, p, b, "R2 routed byte");
            @(negedge clk);
        end

        // R3: stalled output, one crosspoint absorbs DEPTH+1 bytes
        do_reset();
        out_ready[1] = 1'b0;
        for (int k = 0; k < D + 2; k++) begin
            push(0, 1, 0, 'h10 + k, acc);
            chk("R3 acceptance while filling", int'(acc), (k < D + 1) ? 1 : 0);
        end
        // R7: stalled output stage still shows the first byte
        expect_out(1, 0, 0, 'h10, "R7 held byte");

        // R4: same input, other output, not blocked
        push(0, 2, 0, 'h99, acc);
        chk("R4 other destination accepted", int'(acc), 1);
        @(negedge clk);
        expect_out(2, 0, 0, 'h99, "R4 other destination delivered");

        // R8: release, bytes leave in order, one per cycle
        out_ready[1] = 1'b1;
        for (int k = 0; k < D + 1; k++) begin
            expect_out(1, 0, 0, 'h10 + k, "R8 order");
            @(negedge clk);
        end
        chk("R8 column drained", int'(out_valid[1]), 0);

        // R5: three levels arrive together at a stalled output
        do_reset();
        out_ready[3] = 1'b0;
        set_in(1, 3, 0, 'hA0);
        set_in(2, 3, 3, 'hB3);
        set_in(0, 3, 1, 'hC1);
        @(negedge clk);
        in_valid = '0;
        @(negedge clk);
        expect_out(3, 2, 3, 'hB3, "R5 most urgent first");
        out_ready[3] = 1'b1;
        @(negedge clk);
        expect_out(3, 0, 1, 'hC1, "R5 middle level second");
        @(negedge clk);
        expect_out(3, 1, 0, 'hA0, "R5 least urgent last");

        // R6: three inputs, same level, two bytes each
        do_reset();
        out_ready[0] = 1'b0;
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 3; i++) begin
                set_in(i, 0, 2, 'h40 + 16 * i + k);
            end
            @(negedge clk);
        end
        in_valid = '0;
        out_ready[0] = 1'b1;
        for (int n = 0; n < 6; n++) begin
            expect_out(0, n % 3, 2, 'h40 + 16 * (n % 3) + n / 3, "R6 rotation");
            @(negedge clk);
        end

        // R1: reset in the middle of traffic empties a full queue
        out_ready[1] = 1'b0;
        for (int k = 0; k < D + 1; k++) begin
            push(0, 1, 0, k, acc);
        end
        set_in(0, 1, 0, 'h55);
        #1 chk("R1 queue full before reset", int'(in_ready[0]), 0);
        rst = 1'b1;
        in_valid = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        out_ready = '1;
        @(negedge clk);
        set_in(0, 1, 0, 'h55);
        #1 chk("R1 queue empty after reset", int'(in_ready[0]), 1);
        in_valid = '0;
        chk("R1 no stale output after reset", int'(out_valid), 0);
        @(negedge clk);
        chk("R1 nothing queued after reset", int'(out_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule